// File: doc/BRIEF.md
# Serial Port Data FIFO Interface

This block is the data port of a synchronous serial port. One bus location reaches two queues. A bus write pushes into a transmit queue, and a bus read pops from a receive queue. Each queue has its own flags for empty, not-full, full and half-full. The serial side has two parts. A parallel-load shifter takes one word at a time from the transmit queue and sends it MSB first, one bit for each bit-rate enable pulse. A deserializer pushes finished words into the receive queue.

Frame sizes run from 4 to 16 bits. Transmit words are taken right-justified, and any bits above the frame size are ignored. Received words are masked to the frame size, so the upper bits always read as zero. The three-wire command format fixes the transmit width at 8 bits, while receive still follows the programmed size. Dropping the enable input stops new words from starting but keeps both queues intact, so software can load the transmit queue before it turns the port on.

Top module: `sspDataPort`

## Requirements
- R1: Read data bits 31:16 are always 0. Write data bits 31:16 have no effect: only bits 15:0 are stored and sent.
- R2: A write with busWrEn pushes busWrData[15:0] into the transmit queue. A write while txFull is high is dropped, and words leave the queue in the order they were written.
- R3: While busRdEn is high and the receive queue holds data, busRdData shows the oldest word in the same cycle, and that word is removed at the clock edge. A read of an empty queue shows 0 and removes nothing.
- R4: For each queue: empty means a count of 0, full means a count of DEPTH, not-full is the inverse of full, and half means a count of at least DEPTH/2. All four flags are valid from reset, when both queues are empty.
- R5: The shifter loads a new word, and txBusy rises on the next cycle, only while enable is 1, the shifter is idle and the transmit queue is not empty. Each load removes exactly one word.
- R6: While txBusy is high, txOut shows the current bit. txOut changes only on a bitTick edge. The first bit shown is the MSB of the frame, and txBusy falls after the last bitTick of the frame. While idle, txOut is 0.
- R7: The frame size is dataSize+1 bits, with dataSize values 0 to 2 treated as 4 bits. In formats other than the command format, the transmit frame sends only the low frame-size bits of the word.
- R8: With frameFmt = 2'b10 (three-wire command format), every transmit frame is 8 bits, whatever dataSize is.
- R9: A received word is stored with every bit at or above the frame size forced to 0, in every format: 2'b00 plain, 2'b01 synchronous-frame, 2'b10 command. In the command format the receive size still follows dataSize.
- R10: If rxValid is high while the receive queue is full, the word is discarded and rxOverrun is set. rxOverrun stays set until a cycle with clrOverrun high and no new overrun.
- R11: Holding enable at 0 leaves both queues and their flags unchanged, and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; allows new transmit frames to start |
| frameFmt | input | 2 | 00 plain, 01 synchronous-frame, 10 command format |
| dataSize | input | 4 | Frame size minus one |
| busWrEn | input | 1 | Bus write strobe for the data location |
| busWrData | input | 32 | Bus write data |
| busRdEn | input | 1 | Bus read strobe for the data location |
| busRdData | output | 32 | Bus read data (head of the receive queue) |
| clrOverrun | input | 1 | Write-one-to-clear for the overrun flag |
| rxValid | input | 1 | Word from the deserializer is valid |
| rxWord | input | 16 | Word from the deserializer |
| bitTick | input | 1 | Bit-rate enable pulse |
| txOut | output | 1 | Serial transmit bit |
| txBusy | output | 1 | Shifter is sending a frame |
| txEmpty | output | 1 | Transmit queue empty |
| txNotFull | output | 1 | Transmit queue not full |
| txFull | output | 1 | Transmit queue full |
| txHalf | output | 1 | Transmit queue at least half full |
| rxEmpty | output | 1 | Receive queue empty |
| rxNotFull | output | 1 | Receive queue not full |
| rxFull | output | 1 | Receive queue full |
| rxHalf | output | 1 | Receive queue at least half full |
| rxOverrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench builds the block with DEPTH = 4. With that depth, a few writes fill the transmit queue, and the dropped fifth write is observed in the serial stream. A few deserializer words also fill the receive queue, so the overrun path and its clearing are reached quickly. The half-full threshold then falls at two entries, so every flag changes many times during the random phase. Frame sizes of 4, 6, 8, 12 and 16 bits are driven in all three formats, which covers the size clamp, the 8-bit override and the receive masking.

// File: rtl/sspPkg.sv
package sspPkg;
  localparam int DATA_W = 16;
  localparam int BITS_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {
    FMT_PLAIN = 2'b00,
    FMT_SYNC  = 2'b01,
    FMT_CMD   = 2'b10,
    FMT_RSVD  = 2'b11
  } frameFmtE;

  typedef struct packed {
    logic txPush;
    logic txLoad;
    logic txShift;
    logic rxPush;
    logic rxPop;
  } dpStrobeS;

  // frame size in bits from the size code, clamped to the 4-bit minimum
  function automatic logic [BITS_W-1:0] frameBits(input logic [3:0] sizeCode);
    if (sizeCode < 4'd3) return BITS_W'(4);
    return BITS_W'(sizeCode) + BITS_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] sizeMask(input logic [BITS_W-1:0] bits);
    logic [31:0] wide;
    wide = (32'd1 << bits) - 32'd1;
    return wide[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/sspDataCtrl.sv
module sspDataCtrl
  import sspPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              rxValid,
  input  logic              bitTick,
  input  logic              clrOverrun,
  input  logic [BITS_W-1:0] txBits,
  output dpStrobeS          strobe,
  output logic [PTR_W-1:0]  txWrPtr,
  output logic [PTR_W-1:0]  txRdPtr,
  output logic [PTR_W-1:0]  rxWrPtr,
  output logic [PTR_W-1:0]  rxRdPtr,
  output logic              txEmpty,
  output logic              txNotFull,
  output logic              txFull,
  output logic              txHalf,
  output logic              rxEmpty,
  output logic              rxNotFull,
  output logic              rxFull,
  output logic              rxHalf,
  output logic              txBusy,
  output logic              rxOverrun
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0]  txCount, rxCount;
  logic [BITS_W-1:0] bitsLeft;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign txEmpty   = (txCount == '0);
  assign txFull    = (txCount == FULL_CNT);
  assign txNotFull = ~txFull;
  assign txHalf    = (txCount >= HALF_CNT);
  assign rxEmpty   = (rxCount == '0);
  assign rxFull    = (rxCount == FULL_CNT);
  assign rxNotFull = ~rxFull;
  assign rxHalf    = (rxCount >= HALF_CNT);

  always_comb begin
    strobe.txLoad  = !txBusy && enable && !txEmpty;
    strobe.txShift = txBusy && bitTick;
    strobe.txPush  = busWrEn && !txFull;
    strobe.rxPop   = busRdEn && !rxEmpty;
    strobe.rxPush  = rxValid && !rxFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCount   <= '0;
      rxCount   <= '0;
      txWrPtr   <= '0;
      txRdPtr   <= '0;
      rxWrPtr   <= '0;
      rxRdPtr   <= '0;
      txBusy    <= 1'b0;
      bitsLeft  <= '0;
      rxOverrun <= 1'b0;
    end else begin
      txCount <= txCount + CNT_W'(strobe.txPush) - CNT_W'(strobe.txLoad);
      rxCount <= rxCount + CNT_W'(strobe.rxPush) - CNT_W'(strobe.rxPop);
      if (strobe.txPush) txWrPtr <= nextPtr(txWrPtr);
      if (strobe.txLoad) txRdPtr <= nextPtr(txRdPtr);
      if (strobe.rxPush) rxWrPtr <= nextPtr(rxWrPtr);
      if (strobe.rxPop)  rxRdPtr <= nextPtr(rxRdPtr);
      if (strobe.txLoad) begin
        txBusy   <= 1'b1;
        bitsLeft <= txBits;
      end else if (strobe.txShift) begin
        if (bitsLeft == BITS_W'(1)) txBusy <= 1'b0;
        bitsLeft <= bitsLeft - BITS_W'(1);
      end
      if (rxValid && rxFull) rxOverrun <= 1'b1;
      else if (clrOverrun)   rxOverrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sspDataPath.sv
module sspDataPath
  import sspPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeS          strobe,
  input  logic [PTR_W-1:0]  txWrPtr,
  input  logic [PTR_W-1:0]  txRdPtr,
  input  logic [PTR_W-1:0]  rxWrPtr,
  input  logic [PTR_W-1:0]  rxRdPtr,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [BITS_W-1:0] txBits,
  input  logic [BITS_W-1:0] rxBits,
  output logic [DATA_W-1:0] rdWord,
  output logic              txOut
);
  logic [DATA_W-1:0] txMem [DEPTH];
  logic [DATA_W-1:0] rxMem [DEPTH];
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] loadVal;

  // left-justify the masked word so the frame MSB sits at the shifter top
  always_comb
    loadVal = (txMem[txRdPtr] & sizeMask(txBits)) << (BITS_W'(DATA_W) - txBits);

  always_ff @(posedge clk) begin
    if (strobe.txPush) txMem[txWrPtr] <= wrWord;
    if (strobe.rxPush) rxMem[rxWrPtr] <= rxWord & sizeMask(rxBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              shReg <= '0;
    else if (strobe.txLoad)  shReg <= loadVal;
    else if (strobe.txShift) shReg <= shReg << 1;
  end

  assign txOut  = shReg[DATA_W-1];
  assign rdWord = strobe.rxPop ? rxMem[rxRdPtr] : '0;
endmodule

// File: rtl/sspDataPort.sv
module sspDataPort
  import sspPkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BUS_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        frameFmt,
  input  logic [3:0]        dataSize,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              clrOverrun,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              bitTick,
  output logic              txOut,
  output logic              txBusy,
  output logic              txEmpty,
  output logic              txNotFull,
  output logic              txFull,
  output logic              txHalf,
  output logic              rxEmpty,
  output logic              rxNotFull,
  output logic              rxFull,
  output logic              rxHalf,
  output logic              rxOverrun
);
  dpStrobeS          strobe;
  logic [PTR_W-1:0]  txWrPtr, txRdPtr, rxWrPtr, rxRdPtr;
  logic [BITS_W-1:0] txBits, rxBits;
  logic [DATA_W-1:0] rdWord;
  logic              unusedWrHi;

  assign unusedWrHi = |busWrData[BUS_W-1:DATA_W];
  assign rxBits     = frameBits(dataSize);
  assign txBits     = (frameFmtE'(frameFmt) == FMT_CMD) ? BITS_W'(8) : rxBits;
  assign busRdData  = {{(BUS_W-DATA_W){1'b0}}, rdWord};

  sspDataCtrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .rxValid(rxValid), .bitTick(bitTick), .clrOverrun(clrOverrun), .txBits(txBits),
    .strobe(strobe), .txWrPtr(txWrPtr), .txRdPtr(txRdPtr), .rxWrPtr(rxWrPtr),
    .rxRdPtr(rxRdPtr), .txEmpty(txEmpty), .txNotFull(txNotFull), .txFull(txFull),
    .txHalf(txHalf), .rxEmpty(rxEmpty), .rxNotFull(rxNotFull), .rxFull(rxFull),
    .rxHalf(rxHalf), .txBusy(txBusy), .rxOverrun(rxOverrun)
  );

  sspDataPath #(.DEPTH(DEPTH)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWrPtr(txWrPtr), .txRdPtr(txRdPtr),
    .rxWrPtr(rxWrPtr), .rxRdPtr(rxRdPtr), .wrWord(busWrData[DATA_W-1:0]),
    .rxWord(rxWord), .txBits(txBits), .rxBits(rxBits), .rdWord(rdWord), .txOut(txOut)
  );
endmodule

// File: rtl/sspDataPortChk.sv
module sspDataPortChk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             bitTick,
  input logic             busRdEn,
  input logic [BUS_W-1:0] busRdData,
  input logic             rxValid,
  input logic             clrOverrun,
  input logic             rxFull,
  input logic             rxEmpty,
  input logic             txFull,
  input logic             txEmpty,
  input logic             txBusy,
  input logic             txOut,
  input logic             rxOverrun
);
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[BUS_W-1:16] == '0);

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && rxEmpty) |-> (busRdData == '0));

  assert_tx_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty));

  assert_rx_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rxFull && rxEmpty));

  assert_no_start_disabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !txBusy) |=> !txBusy);

  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !bitTick) |=> txBusy);

  assert_bit_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !bitTick) |=> $stable(txOut));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !txOut);

  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFull) |=> rxOverrun);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverrun && !clrOverrun) |=> rxOverrun);
endmodule

bind sspDataPort sspDataPortChk #(.BUS_W(BUS_W)) i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .bitTick(bitTick), .busRdEn(busRdEn),
  .busRdData(busRdData), .rxValid(rxValid), .clrOverrun(clrOverrun), .rxFull(rxFull),
  .rxEmpty(rxEmpty), .txFull(txFull), .txEmpty(txEmpty), .txBusy(txBusy),
  .txOut(txOut), .rxOverrun(rxOverrun)
);

// File: tb/test_sspDataPort.sv
`timescale 1ns/1ps
module test_sspDataPort;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  frameFmt = 2'b00;
  logic [3:0]  dataSize = 4'd15;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        clrOverrun = 1'b0;
  logic        rxValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic        bitTick = 1'b0;
  logic        txOut, txBusy, txEmpty, txNotFull, txFull, txHalf;
  logic        rxEmpty, rxNotFull, rxFull, rxHalf, rxOverrun;

  int checks = 0;
  int fails = 0;

  sspDataPort #(.DEPTH(DEPTH)) i_sspDataPort (
    .clk(clk), .rstN(rstN), .enable(enable), .frameFmt(frameFmt), .dataSize(dataSize),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .clrOverrun(clrOverrun), .rxValid(rxValid), .rxWord(rxWord), .bitTick(bitTick),
    .txOut(txOut), .txBusy(txBusy), .txEmpty(txEmpty), .txNotFull(txNotFull),
    .txFull(txFull), .txHalf(txHalf), .rxEmpty(rxEmpty), .rxNotFull(rxNotFull),
    .rxFull(rxFull), .rxHalf(rxHalf), .rxOverrun(rxOverrun)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  logic [15:0] mTx[$];
  logic [15:0] mRx[$];
  logic [15:0] mSh;
  int          mIdx = 0;
  bit          mBusy = 0;
  bit          mOvr = 0;

  function automatic int bitsOf(input logic [1:0] fmt, input logic [3:0] ds, input bit isTx);
    if (isTx && fmt == 2'b10) return 8;
    return (ds < 3) ? 4 : int'(ds) + 1;
  endfunction

  function automatic logic [15:0] maskOf(input int bits);
    return 16'((32'd1 << bits) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTx.delete(); mRx.delete(); mBusy = 0; mOvr = 0; mIdx = 0;
    end else begin
      int preTx, preRx, b;
      preTx = mTx.size();
      preRx = mRx.size();
      if (!mBusy) begin
        if (enable && preTx > 0) begin
          b = bitsOf(frameFmt, dataSize, 1);
          mSh = mTx.pop_front() & maskOf(b);
          mIdx = b - 1;
          mBusy = 1;
        end
      end else if (bitTick) begin
        if (mIdx == 0) mBusy = 0;
        else mIdx--;
      end
      if (busWrEn && preTx < DEPTH) mTx.push_back(busWrData[15:0]);
      if (busRdEn && preRx > 0) void'(mRx.pop_front());
      if (rxValid && preRx < DEPTH) mRx.push_back(rxWord & maskOf(bitsOf(frameFmt, dataSize, 0)));
      if (rxValid && preRx == DEPTH) mOvr = 1;
      else if (clrOverrun) mOvr = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // serial capture of transmitted frames
  int          capBits = 16;
  int          capCnt = 0;
  logic [15:0] capWord = '0;
  logic [15:0] capQ[$];
  bit          tickOn = 0;
  int          tickCnt = 0;

  task automatic compareAll();
    logic [31:0] expRd;
    int n, nr;
    n = mTx.size(); nr = mRx.size();
    expRd = (busRdEn && nr > 0) ? {16'h0, mRx[0]} : 32'h0;
    check("R3 read data", busRdData, expRd);
    check("R1 upper read bits", {16'h0, busRdData[31:16]}, 32'h0);
    check("R5 busy", 32'(txBusy), 32'(mBusy));
    check("R6 serial bit", 32'(txOut), mBusy ? 32'(mSh[mIdx]) : 32'h0);
    check("R4 tx flags", {28'h0, txEmpty, txNotFull, txFull, txHalf},
          {28'h0, n == 0, n != DEPTH, n == DEPTH, n >= DEPTH / 2});
    check("R4 rx flags", {28'h0, rxEmpty, rxNotFull, rxFull, rxHalf},
          {28'h0, nr == 0, nr != DEPTH, nr == DEPTH, nr >= DEPTH / 2});
    check("R10 overrun", 32'(rxOverrun), 32'(mOvr));
  endtask

  // called right after a negedge with inputs set; compares, then advances one cycle
  task automatic cyc();
    bitTick = tickOn && (tickCnt % 3 == 2);
    tickCnt++;
    #1;
    compareAll();
    if (txBusy && bitTick) begin
      capWord = {capWord[14:0], txOut};
      capCnt++;
      if (capCnt == capBits) begin
        capQ.push_back(capWord & maskOf(capBits));
        capCnt = 0; capWord = '0;
      end
    end
    @(negedge clk);
    busWrEn = 0; busRdEn = 0; rxValid = 0; clrOverrun = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    busWrEn = 1; busWrData = d; cyc();
  endtask

  task automatic rxPush(input logic [15:0] d);
    rxValid = 1; rxWord = d; cyc();
  endtask

  task automatic rdCheck(input string req, input logic [31:0] exp);
    busRdEn = 1;
    #1 check(req, busRdData, exp);
    cyc();
  endtask

  task automatic drain();
    for (int i = 0; i < 600; i++) begin
      if (txEmpty && !txBusy) break;
      cyc();
    end
    cyc();
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state R4, R6
    check("R4 reset tx empty", 32'(txEmpty), 32'h1);
    check("R4 reset rx empty", 32'(rxEmpty), 32'h1);
    check("R6 reset idle out", 32'(txOut), 32'h0);

    // R11 and R2: preload while disabled, fifth write dropped
    wr(32'hDEAD_8001); wr(32'h0000_1234); wr(32'h0000_F00F); wr(32'h0000_0ABC);
    wr(32'h0000_5555);
    check("R2 tx full after fill", 32'(txFull), 32'h1);
    for (int i = 0; i < 10; i++) cyc();
    check("R11 queue kept while disabled", 32'(txFull), 32'h1);
    check("R11 no frame while disabled", 32'(txBusy), 32'h0);
    enable = 1; tickOn = 1; capBits = 16;
    drain();
    check("R2 frames sent", capQ.size(), 4);
    if (capQ.size() == 4) begin
      check("R1 upper write bits ignored, R6 MSB first", capQ[0], 32'h8001);
      check("R2 order 2", capQ[1], 32'h1234);
      check("R2 order 3", capQ[2], 32'hF00F);
      check("R2 order 4", capQ[3], 32'h0ABC);
    end
    capQ.delete();

    // R7: 8-bit and clamped 4-bit frames
    dataSize = 4'd7; capBits = 8;
    wr(32'h0000_A5C3); drain();
    check("R7 8-bit frame", capQ.size() > 0 ? capQ[0] : 16'hFFFF, 32'h00C3);
    capQ.delete();
    dataSize = 4'd1; capBits = 4;
    wr(32'h0000_00F9); drain();
    check("R7 clamp to 4 bits", capQ.size() > 0 ? capQ[0] : 16'hFFFF, 32'h0009);
    capQ.delete();

    // R8: command format forces 8-bit transmit
    frameFmt = 2'b10; dataSize = 4'd11; capBits = 8;
    wr(32'h0000_1F2E); drain();
    check("R8 command tx 8 bits", capQ.size() > 0 ? capQ[0] : 16'hFFFF, 32'h002E);
    capQ.delete();

    // R9: receive masking per format
    frameFmt = 2'b01; dataSize = 4'd5;
    rxPush(16'hFFFF);
    rdCheck("R9 sync-frame rx masked", 32'h0000_003F);
    frameFmt = 2'b10; dataSize = 4'd11;
    rxPush(16'hFABC);
    rdCheck("R9 command rx follows size", 32'h0000_0ABC);

    // R10 and R3: overrun, clear, ordered reads, empty read
    frameFmt = 2'b00; dataSize = 4'd15;
    rxPush(16'h1111); rxPush(16'h2222); rxPush(16'h3333); rxPush(16'h4444);
    rxPush(16'h5555);
    check("R10 overrun set", 32'(rxOverrun), 32'h1);
    cyc();
    check("R10 overrun sticky", 32'(rxOverrun), 32'h1);
    clrOverrun = 1; cyc();
    check("R10 overrun cleared", 32'(rxOverrun), 32'h0);
    rdCheck("R3 pop 1", 32'h1111);
    rdCheck("R3 pop 2", 32'h2222);
    rdCheck("R3 pop 3", 32'h3333);
    rdCheck("R10 fifth discarded", 32'h4444);
    rdCheck("R3 empty read zero", 32'h0);
    check("R3 empty read moves nothing", 32'(rxEmpty), 32'h1);

    // random mixed traffic against the model
    tickOn = 1;
    for (int i = 0; i < 3000; i++) begin
      enable     = ($urandom % 8) != 0;
      frameFmt   = 2'($urandom % 3);
      dataSize   = 4'($urandom);
      busWrEn    = ($urandom % 3) == 0;
      busWrData  = $urandom;
      busRdEn    = ($urandom % 3) == 0;
      rxValid    = ($urandom % 3) == 0;
      rxWord     = 16'($urandom);
      clrOverrun = ($urandom % 10) == 0;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule